// File: doc/BRIEF.md
# Saturating Calibration Wiper Counter

This block is the digital core of a closed-loop gate-bias trimmer. It keeps an 8-bit tap position for a 256-tap bias divider. While the calibration enable is high, each falling edge of the shared serial clock moves the position by exactly one tap. A comparator-direction bit sets the direction of the step. The position stops at both ends and never wraps around. When the calibration enable is low, the position holds and the serial clock is left to the serial bus. A synchronous load port lets register writes and power-up recall place any code directly.

All four pin inputs (enable, serial clock, direction, shutdown) pass through two-flop synchronizers to a faster system clock. Whenever the direction bit changes while calibration is enabled, the block takes a snapshot of the current code and reports it with a one-cycle pulse.

The shutdown pin forces the gate-driver enable low and keeps the code. A small state machine then blocks stepping until the enable has been seen low and then high again. Its states and transitions are:
- `ST_RUN`: normal operation. Shutdown high moves it to `ST_SHDN`.
- `ST_SHDN`: driver disabled. Shutdown low moves it to `ST_WAIT_LO`.
- `ST_WAIT_LO`: enable low moves it to `ST_WAIT_HI`.
- `ST_WAIT_HI`: enable high moves it to `ST_RUN`.

Shutdown high sends every state to `ST_SHDN`.

Top module: `bias_wiper_ctrl`

## Requirements
- R1: Each synchronized falling edge of `scl_in`, with `cs_in` high in state `ST_RUN`, changes `code_out` by exactly one tap. The code changes no more than one tap per system clock unless a load is applied.
- R2: A step increments the code when `dir_in` is 1 and decrements it when `dir_in` is 0.
- R3: The code saturates at 0 and at 255. A decrement at 0 and an increment at 255 leave it unchanged.
- R4: With `cs_in` low, `scl_in` edges leave `code_out` unchanged.
- R5: While `cs_in` is high, a rising or a falling edge of `dir_in` copies the current code to `lock_code` and raises `lock_pulse` for one system clock. Edges of `dir_in` with `cs_in` low produce no pulse.
- R6: While `shdn_in` is high, `drv_en` is 0, the code is kept, and serial clock edges cause no steps.
- R7: After `shdn_in` falls, stepping stays blocked until `cs_in` has been seen low and then high.
- R8: After reset, `code_out` is 0, `drv_en` is 1 and `lock_pulse` is 0.
- R9: When `load_valid` is high, `code_out` takes `load_code` at the next clock edge, and this overrides any step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_in | input | 1 | Calibration enable pin (asynchronous) |
| scl_in | input | 1 | Shared serial clock pin (asynchronous) |
| dir_in | input | 1 | Comparator direction, 1 = up (asynchronous) |
| shdn_in | input | 1 | Shutdown pin, active high (asynchronous) |
| load_valid | input | 1 | Load request from register write or recall |
| load_code | input | 8 | Code to load |
| code_out | output | 8 | Current wiper tap position |
| lock_pulse | output | 1 | One-cycle snapshot event |
| lock_code | output | 8 | Code captured at the last direction change |
| drv_en | output | 1 | Gate-driver output enable |

## Verification
The bench drives the code into both ends and keeps clocking there. A counter that wraps would jump to the opposite end instead of staying put. It toggles the direction with the enable both high and low. This catches a snapshot taken only on one edge polarity, or taken while disabled. It holds a load across a serial clock fall, so a step that wins over the load would leave the code off by one. After shutdown it clocks with the enable still high, where a missing re-arm would resume stepping at once, and then checks that stepping returns only after a low-high cycle of the enable.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SHDN    = 2'd1,
        ST_WAIT_LO = 2'd2,
        ST_WAIT_HI = 2'd3
    } arm_state_t;
endpackage

// File: rtl/bwc_sync.sv
module bwc_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
            end
        end
        assign sync_out[g] = stab_q;
    end
endmodule

// File: rtl/bwc_arm_fsm.sv
module bwc_arm_fsm
    import bwc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic shdn_s,
    output logic step_ok,
    output logic drv_en
);
    arm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (shdn_s) state_d = ST_SHDN;
            ST_SHDN:    if (!shdn_s) state_d = ST_WAIT_LO;
            ST_WAIT_LO: if (shdn_s) state_d = ST_SHDN;
                        else if (!cs_s) state_d = ST_WAIT_HI;
            ST_WAIT_HI: if (shdn_s) state_d = ST_SHDN;
                        else if (cs_s) state_d = ST_RUN;
            default:    state_d = ST_SHDN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        step_ok = (state_q == ST_RUN);
        drv_en  = (state_q != ST_SHDN);
    end

    AST_SHDN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_s |=> !drv_en); // R6
    AST_REARM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHDN) |=> !step_ok); // R7
    AST_REARM_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_LO) |=> !step_ok); // R7
endmodule

// File: rtl/bwc_counter.sv
module bwc_counter #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              up,
    input  logic              ld,
    input  logic [CODE_W-1:0] ld_code,
    output logic [CODE_W-1:0] code_q
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    localparam logic [CODE_W-1:0] ONE      = {{(CODE_W-1){1'b0}}, 1'b1};

    logic [CODE_W-1:0] code_d;

    always_comb begin
        code_d = code_q;
        if (ld)
            code_d = ld_code;
        else if (step && up && code_q != CODE_MAX)
            code_d = code_q + ONE;
        else if (step && !up && code_q != CODE_MIN)
            code_d = code_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= CODE_MIN;
        else        code_q <= code_d;
    end

    AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (code_q == $past(code_q) || code_q == $past(code_q) + ONE
                 || code_q == $past(code_q) - ONE)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_MAX && !ld) |=> code_q != CODE_MIN); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == CODE_MIN && !ld) |=> code_q != CODE_MAX); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld) |=> $stable(code_q)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> code_q == $past(ld_code)); // R9
endmodule

// File: rtl/bias_wiper_ctrl.sv
module bias_wiper_ctrl #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_in,
    input  logic              scl_in,
    input  logic              dir_in,
    input  logic              shdn_in,
    input  logic              load_valid,
    input  logic [CODE_W-1:0] load_code,
    output logic [CODE_W-1:0] code_out,
    output logic              lock_pulse,
    output logic [CODE_W-1:0] lock_code,
    output logic              drv_en
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] pins_s;
    logic cs_s, scl_s, dir_s, shdn_s;
    logic scl_prev_q, dir_prev_q;
    logic scl_fall, dir_edge, step_ok, step;

    bwc_sync #(.WIDTH(NSYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({shdn_in, dir_in, scl_in, cs_in}),
        .sync_out (pins_s)
    );
    assign {shdn_s, dir_s, scl_s, cs_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b0;
            dir_prev_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_s;
            dir_prev_q <= dir_s;
        end
    end

    assign scl_fall = scl_prev_q & ~scl_s;
    assign dir_edge = dir_prev_q ^ dir_s;

    bwc_arm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .shdn_s  (shdn_s),
        .step_ok (step_ok),
        .drv_en  (drv_en)
    );

    assign step = scl_fall & cs_s & step_ok;

    bwc_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .up      (dir_s),
        .ld      (load_valid),
        .ld_code (load_code),
        .code_q  (code_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_pulse <= 1'b0;
            lock_code  <= '0;
        end else begin
            lock_pulse <= dir_edge & cs_s;
            if (dir_edge && cs_s) lock_code <= code_out;
        end
    end

    AST_LOCK_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        lock_pulse |-> lock_code == $past(code_out)); // R5
    AST_LOCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !lock_pulse); // R5
    AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !load_valid) |=> $stable(code_out)); // R4
endmodule

// File: tb/bias_wiper_ctrl_bench.sv
module bias_wiper_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_in = 1'b0, scl_in = 1'b1, dir_in = 1'b0, shdn_in = 1'b0;
    logic       load_valid = 1'b0;
    logic [7:0] load_code = 8'd0;
    logic [7:0] code_out, lock_code;
    logic       lock_pulse, drv_en;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    logic [7:0] last_lock = 8'd0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bias_wiper_ctrl u_bias_wiper_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .scl_in(scl_in),
        .dir_in(dir_in), .shdn_in(shdn_in), .load_valid(load_valid),
        .load_code(load_code), .code_out(code_out), .lock_pulse(lock_pulse),
        .lock_code(lock_code), .drv_en(drv_en)
    );

    always @(negedge clk) begin
        if (rst_n && lock_pulse) begin
            pulses++;
            last_lock = lock_code;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic scl_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            scl_in = 1'b0;
            settle();
            scl_in = 1'b1;
            settle();
        end
    endtask

    task automatic do_load(input logic [7:0] v);
        @(negedge clk);
        load_code  = v;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R8 code", code_out, 0);
        check("R8 drv_en", drv_en, 1);
        check("R8 lock_pulse", lock_pulse, 0);
    endtask

    task automatic t_up_down();
        dir_in = 1'b1;
        settle();
        cs_in = 1'b1;
        settle();
        scl_pulses(5);
        check("R1 R2 up five", code_out, 5);
        pulses = 0;
        dir_in = 1'b0;
        settle();
        check("R5 pulse on falling dir", pulses, 1);
        check("R5 snapshot", last_lock, 5);
        scl_pulses(2);
        check("R2 down two", code_out, 3);
        dir_in = 1'b1;
        settle();
        check("R5 pulse on rising dir", pulses, 2);
        check("R5 snapshot rise", last_lock, 3);
        dir_in = 1'b0;
        settle();
    endtask

    task automatic t_clamp();
        scl_pulses(6);
        check("R3 floor", code_out, 0);
        do_load(8'd250);
        settle();
        check("R9 load", code_out, 250);
        dir_in = 1'b1;
        settle();
        scl_pulses(8);
        check("R3 ceiling", code_out, 255);
    endtask

    task automatic t_cs_low();
        cs_in = 1'b0;
        settle();
        pulses = 0;
        scl_pulses(3);
        check("R4 hold with cs low", code_out, 255);
        dir_in = 1'b0;
        settle();
        dir_in = 1'b1;
        settle();
        check("R5 no pulse with cs low", pulses, 0);
    endtask

    task automatic t_load_collide();
        do_load(8'd100);
        cs_in  = 1'b1;
        dir_in = 1'b1;
        settle();
        @(negedge clk);
        load_code  = 8'd40;
        load_valid = 1'b1;
        scl_in = 1'b0;
        repeat (8) @(negedge clk);
        load_valid = 1'b0;
        settle();
        scl_in = 1'b1;
        settle();
        check("R9 load beats step", code_out, 40);
    endtask

    task automatic t_shutdown();
        scl_pulses(1);
        check("R1 step before shutdown", code_out, 41);
        shdn_in = 1'b1;
        settle();
        check("R6 driver off", drv_en, 0);
        scl_pulses(2);
        check("R6 code kept", code_out, 41);
        shdn_in = 1'b0;
        settle();
        check("R6 driver back", drv_en, 1);
        scl_pulses(2);
        check("R7 blocked before cs cycle", code_out, 41);
        cs_in = 1'b0;
        settle();
        cs_in = 1'b1;
        settle();
        scl_pulses(2);
        check("R7 steps after cs cycle", code_out, 43);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_up_down();
        t_clamp();
        t_cs_low();
        t_load_collide();
        t_shutdown();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule